// File: doc/BRIEF.md
# Half-Bridge Current-Sense Fault Detector

This block watches two digital comparator flags that describe the current in the low-side switch of a half-bridge. It raises a fault pulse when the current is out of range, and it judges each switching cycle on its own. One flag reports excess current. It is checked on every clock while the mode sequencer arms it, which is from ignition onward. This check catches a lamp that fails to strike, plain over-current and hard switching. The other flag reports current below the lower threshold. It is looked at only once per switching cycle, at the instant the low-side drive turns off, and only while the sequencer arms it in run mode. A set flag at that instant means the bridge runs with no load or below resonance.

Both comparator flags arrive asynchronously, so each passes through a synchronizer before it is used. The low-side drive is a synchronous signal from the gate-drive logic, and a registered copy of it detects its falling edge. A detected fault gives a single-clock pulse together with a 2-bit cause code. After a pulse the block stays silent until the sequencer has dropped both arm inputs in the same clock. The analog thresholds and any filtering are outside this block.

Top module: `cs_fault_detect`

## Requirements
- R1: While reset is active and on the first cycle after it, `fault_pulse` is 0 and `fault_cause` is 2'b00.
- R2: With `oc_arm` high, an over-current flag that is set before rising edge k gives `fault_pulse`=1 with `fault_cause`=2'b01 after edge k+2. The two edges of delay come from the synchronizer and the third register is the output stage.
- R3: The over-current flag has no effect while `oc_arm` is low.
- R4: The under-current flag is judged only at the low-side turn-off. Edge k counts as a turn-off when `lo_drive` was high at edge k-1 and is low at edge k. If the synchronized flag is set then and `uc_arm` is high, `fault_pulse`=1 with `fault_cause`=2'b10 after edge k. A set flag has no effect at any other time.
- R5: The under-current flag has no effect while `uc_arm` is low.
- R6: When both checks fire at the same edge, the cause reported is over-current (2'b01).
- R7: `fault_pulse` is never high on two consecutive cycles.
- R8: After a pulse, no further pulse occurs until an edge at which both `oc_arm` and `uc_arm` are low. After that edge a new fault is reported again.
- R9: `fault_cause` is 2'b00 whenever `fault_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc_flag_async | input | 1 | Over-current comparator flag, asynchronous |
| uc_low_async | input | 1 | High when current is below the lower threshold, asynchronous |
| lo_drive | input | 1 | Low-side gate drive, synchronous to clk |
| oc_arm | input | 1 | Enables the over-current check |
| uc_arm | input | 1 | Enables the under-current check |
| fault_pulse | output | 1 | One-clock fault indication |
| fault_cause | output | 2 | 01 over-current, 10 under-current, 00 otherwise |

## Verification
Several directed patterns separate the cases that matter:
- A lone over-current flag measures the three-edge latency.
- An under-current flag held steady while the low-side drive stays high, and then stays low, shows that a level alone never trips the check. Only the turn-off edge does.
- Simultaneous hits expose the priority.
- Keeping one arm high shows the lockout holds, and dropping both arms shows the block re-arms.

After these, random drive periods, arm changes and sparse flag pulses are compared cycle by cycle against a reference model in the bench. This catches errors in edge alignment or gating that the directed cases miss.

// File: rtl/cs_fault_pkg.sv
package cs_fault_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_OC   = 2'b01,
        CAUSE_UC   = 2'b10
    } cause_e;

    typedef struct packed {
        logic   pulse;
        cause_e cause;
        logic   lock;
    } core_state_t;

    typedef struct packed {
        logic lo_prev;
    } edge_state_t;

endpackage

// File: rtl/cs_sync.sv
module cs_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[LAST];
endmodule

// File: rtl/cs_lo_edge.sv
module cs_lo_edge
    import cs_fault_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lo_drive,
    output logic lo_fall
);
    edge_state_t st_d, st_q;

    always_comb begin
        st_d.lo_prev = lo_drive;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // turn-off seen when the stored copy is high and the live drive is low
    assign lo_fall = st_q.lo_prev & ~lo_drive;
endmodule

// File: rtl/cs_fault_core.sv
module cs_fault_core
    import cs_fault_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       oc_seen,
    input  logic       uc_seen,
    input  logic       lo_fall,
    input  logic       oc_arm,
    input  logic       uc_arm,
    output logic       pulse,
    output logic [1:0] cause
);
    core_state_t st_d, st_q;
    logic oc_hit, uc_hit, fire, disarmed;

    always_comb begin
        oc_hit   = oc_arm & oc_seen;
        uc_hit   = uc_arm & uc_seen & lo_fall;
        fire     = ~st_q.lock & (oc_hit | uc_hit);
        disarmed = ~oc_arm & ~uc_arm;

        st_d       = st_q;
        st_d.pulse = fire;
        st_d.cause = CAUSE_NONE;
        if (fire) begin
            st_d.cause = oc_hit ? CAUSE_OC : CAUSE_UC;
        end
        if (disarmed)  st_d.lock = 1'b0;
        else if (fire) st_d.lock = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse = st_q.pulse;
    assign cause = st_q.cause;
endmodule

// File: rtl/cs_fault_detect.sv
module cs_fault_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       oc_flag_async,
    input  logic       uc_low_async,
    input  logic       lo_drive,
    input  logic       oc_arm,
    input  logic       uc_arm,
    output logic       fault_pulse,
    output logic [1:0] fault_cause
);
    localparam int NFLAG = 2;

    logic [NFLAG-1:0] flag_s;
    logic             lo_fall;

    cs_sync #(.WIDTH(NFLAG), .STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({uc_low_async, oc_flag_async}),
        .dout (flag_s)
    );

    cs_lo_edge i_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .lo_drive(lo_drive),
        .lo_fall (lo_fall)
    );

    cs_fault_core i_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .oc_seen(flag_s[0]),
        .uc_seen(flag_s[1]),
        .lo_fall(lo_fall),
        .oc_arm (oc_arm),
        .uc_arm (uc_arm),
        .pulse  (fault_pulse),
        .cause  (fault_cause)
    );
endmodule

// File: rtl/cs_fault_detect_chk.sv
module cs_fault_detect_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       lo_drive,
    input logic       oc_arm,
    input logic       uc_arm,
    input logic       fault_pulse,
    input logic [1:0] fault_cause
);
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                seen_q <= 1'b0;
        else if (!oc_arm && !uc_arm) seen_q <= 1'b0;
        else if (fault_pulse)      seen_q <= 1'b1;
    end

    p_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_pulse |=> !fault_pulse);

    p_idle_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_pulse |-> fault_cause == 2'b00);

    p_legal_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fault_pulse |-> (fault_cause == 2'b01 || fault_cause == 2'b10));

    p_oc_armed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_pulse && fault_cause == 2'b01) |-> $past(oc_arm));

    p_uc_at_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_pulse && fault_cause == 2'b10) |-> ($past(lo_drive, 2) && !$past(lo_drive)));

    p_uc_armed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_pulse && fault_cause == 2'b10) |-> $past(uc_arm));

    p_lockout_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> !fault_pulse);
endmodule

bind cs_fault_detect cs_fault_detect_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lo_drive   (lo_drive),
    .oc_arm     (oc_arm),
    .uc_arm     (uc_arm),
    .fault_pulse(fault_pulse),
    .fault_cause(fault_cause)
);

// File: tb/test_cs_fault_detect.sv
module test_cs_fault_detect;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       oc_flag_async = 1'b0;
    logic       uc_low_async = 1'b0;
    logic       lo_drive = 1'b0;
    logic       oc_arm = 1'b0;
    logic       uc_arm = 1'b0;
    logic       fault_pulse;
    logic [1:0] fault_cause;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    // reference model state
    bit       m_oc1, m_oc2, m_uc1, m_uc2, m_lo, m_lock, m_pulse;
    bit [1:0] m_cause;

    always #10 clk = ~clk;

    cs_fault_detect i_cs_fault_detect (
        .clk(clk), .rst_n(rst_n), .oc_flag_async(oc_flag_async),
        .uc_low_async(uc_low_async), .lo_drive(lo_drive), .oc_arm(oc_arm),
        .uc_arm(uc_arm), .fault_pulse(fault_pulse), .fault_cause(fault_cause)
    );

    function automatic bit [1:0] pick_cause(bit oc_hit, bit uc_hit);
        if (oc_hit)      return 2'b01;
        else if (uc_hit) return 2'b10;
        return 2'b00;
    endfunction

    task automatic chk(string tag, bit [2:0] act, bit [2:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: pulse/cause actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_oc1 = 0; m_oc2 = 0; m_uc1 = 0; m_uc2 = 0;
        m_lo = 0; m_lock = 0; m_pulse = 0; m_cause = 2'b00;
    endtask

    // one clock: edge, model update, compare at the falling clock edge
    task automatic tick(string tag);
        bit fall, oc_hit, uc_hit;
        @(posedge clk);
        fall   = m_lo && !lo_drive;
        oc_hit = oc_arm && m_oc2;
        uc_hit = uc_arm && m_uc2 && fall;
        m_pulse = !m_lock && (oc_hit || uc_hit);
        m_cause = m_pulse ? pick_cause(oc_hit, uc_hit) : 2'b00;
        if (!oc_arm && !uc_arm) m_lock = 0;
        else if (m_pulse)       m_lock = 1;
        m_lo  = lo_drive;
        m_oc2 = m_oc1; m_oc1 = oc_flag_async;
        m_uc2 = m_uc1; m_uc1 = uc_low_async;
        @(negedge clk);
        chk(tag, {fault_pulse, fault_cause}, {m_pulse, m_cause});
    endtask

    task automatic ticks(int n, string tag);
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    task automatic disarm_all();
        oc_arm = 0; uc_arm = 0; oc_flag_async = 0; uc_low_async = 0;
        ticks(3, "R8");
    endtask

    initial begin
        #4_000_000;
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        chk("R1 in reset", {fault_pulse, fault_cause}, 3'b000);
        rst_n = 1;
        tick("R1 after reset");
        chk("R1", {fault_pulse, fault_cause}, 3'b000);

        // R2 latency: flag set before edge 1, pulse after edge 3
        oc_arm = 1; oc_flag_async = 1;
        tick("R2"); chk("R2 edge1", {fault_pulse, fault_cause}, 3'b000);
        tick("R2"); chk("R2 edge2", {fault_pulse, fault_cause}, 3'b000);
        tick("R2"); chk("R2 edge3", {fault_pulse, fault_cause}, 3'b101);
        tick("R7"); chk("R7 single", {fault_pulse, fault_cause[1:0]}, 3'b000);
        ticks(4, "R8 held");
        disarm_all();

        // R3: flag with arm low
        oc_flag_async = 1;
        ticks(6, "R3");
        chk("R3 ignored", {fault_pulse, fault_cause}, 3'b000);
        oc_flag_async = 0;
        ticks(3, "R3");

        // R4: level alone never trips, LO high then low steadily
        uc_arm = 1; uc_low_async = 1; lo_drive = 1;
        ticks(5, "R4 lo high");
        chk("R4 lo high", {fault_pulse, fault_cause}, 3'b000);
        lo_drive = 0;
        tick("R4 fall"); chk("R4 fall", {fault_pulse, fault_cause}, 3'b110);
        ticks(5, "R4 lo low");
        chk("R4 lo low", {fault_pulse, fault_cause}, 3'b000);
        disarm_all();

        // R5: under-current with arm low, through a turn-off
        uc_low_async = 1; lo_drive = 1;
        ticks(4, "R5");
        lo_drive = 0;
        tick("R5"); chk("R5 ignored", {fault_pulse, fault_cause}, 3'b000);
        ticks(2, "R5");
        uc_low_async = 0;
        ticks(2, "R5");

        // R6: both hit the same edge
        oc_arm = 1; uc_arm = 1; lo_drive = 1;
        ticks(2, "R6");
        oc_flag_async = 1; uc_low_async = 1;
        ticks(2, "R6");
        lo_drive = 0;
        tick("R6"); chk("R6 priority", {fault_pulse, fault_cause}, 3'b101);
        oc_flag_async = 0;

        // R8: one arm kept high keeps the lockout
        oc_arm = 0;
        for (int c = 0; c < 3; c++) begin
            lo_drive = 1; ticks(3, "R8");
            lo_drive = 0; tick("R8 locked");
            chk("R8 locked", {fault_pulse, fault_cause}, 3'b000);
        end
        uc_arm = 0; tick("R8 release");
        uc_arm = 1; lo_drive = 1; ticks(2, "R8");
        lo_drive = 0; tick("R8 rearmed");
        chk("R8 rearmed", {fault_pulse, fault_cause}, 3'b110);
        disarm_all();

        // random phase against the model
        begin
            int period = 6;
            int phase = 0;
            for (int n = 0; n < 6000; n++) begin
                if (phase == 0) period = 4 + ($urandom % 7);
                lo_drive = (phase < period / 2);
                phase = (phase + 1 >= period) ? 0 : phase + 1;
                if (($urandom % 40) == 0) oc_arm = $urandom % 2;
                if (($urandom % 40) == 0) uc_arm = $urandom % 2;
                oc_flag_async = (($urandom % 25) == 0);
                uc_low_async  = (($urandom % 6) == 0);
                tick("R2 R4 R6 R8 random");
            end
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule